// File: doc/BRIEF.md
# Desaturation Short-Circuit Supervisor

This block is the digital supervisor for short-circuit protection in an isolated gate driver. It watches a comparator flag that rises when the desaturation sense node charges past its programmed threshold. While the switch is commanded on, a consecutive run of high samples of the required length is treated as a confirmed short circuit. The confirmed fault latches. The gate command is then forced to a configurable safe level, and a turn-off style is reported to the output stage.

The block also drives the sense network's support controls. The charge-current enable follows the on phase of the switch. The blanking-node discharge pulses once on every falling PWM edge when that feature is enabled. A sticky status bit records the event, and an active-low fault pin reports it unless it is masked. The latch releases only through a clear strobe, and only while the comparator is back low.

Top module: `desat_guard`

## Requirements
- R1: When `cfg_prot_en` is 0, `cmp_trip` has no effect: `stat_desat` stays 0 and `flt_n` stays 1.
- R2: `chg_en` is 1 exactly when `pwm_in` is 1 and no fault is latched.
- R3: When `cfg_dchg_en` is 1, a 1-to-0 change of `pwm_in` sampled at a clock edge makes `dchg_en` high for exactly the following clock cycle. When `cfg_dchg_en` is 0, `dchg_en` stays 0.
- R4: A fault is confirmed at the Nth consecutive clock edge at which `cmp_trip`, `pwm_in` and `cfg_prot_en` are all 1. N is 4 when `cfg_glitch_long` is 0 and 16 when it is 1. Any edge without that condition restarts the count.
- R5: While a fault is latched, `gate_out` equals `cfg_safe_high` whatever `pwm_in` does. Otherwise `gate_out` follows `pwm_in`.
- R6: While a fault is latched, `off_style` reports the turn-off style. It reports 00 (hard) for `cfg_off_mode` 00 or 11, 01 (soft) for 01, and 10 (two-level) for 10. With no fault latched it reports 00.
- R7: `stat_desat` is set by a confirmed fault and is sticky. It clears at a clock edge with `clr_stb`=1 only when `cmp_trip` is 0 at that edge.
- R8: `flt_n` is 0 exactly while a fault is latched and `mask_flt` is 0.
- R9: For two-level turn-off, `mid_level` is 1 for exactly 32 cycles, starting with the cycle after the confirming edge, and then returns to 0 while the fault stays latched.
- R10: While `pwm_in` is 0, `cmp_trip` is ignored and the deglitch count restarts from zero.
- R11: After reset, `stat_desat`=0, `flt_n`=1, `off_style`=00, `mid_level`=0, `dchg_en`=0, and `gate_out` follows `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM on/off command |
| cmp_trip | input | 1 | Desaturation comparator flag |
| cfg_prot_en | input | 1 | Protection enable |
| cfg_glitch_long | input | 1 | Deglitch length select: 0 gives 4 cycles, 1 gives 16 |
| cfg_safe_high | input | 1 | Safe gate level on fault |
| cfg_off_mode | input | 2 | Turn-off style field |
| cfg_dchg_en | input | 1 | Blanking discharge enable |
| mask_flt | input | 1 | Fault pin mask |
| clr_stb | input | 1 | Status clear strobe |
| gate_out | output | 1 | Gate-drive command |
| off_style | output | 2 | Active turn-off style |
| mid_level | output | 1 | Two-level intermediate phase indication |
| chg_en | output | 1 | Charge-current enable |
| dchg_en | output | 1 | Blanking-node discharge pulse |
| stat_desat | output | 1 | Sticky desaturation status |
| flt_n | output | 1 | Active-low fault pin |

## Verification
The hardest state to reach is the boundary of the deglitch window. The bench has to hold the flag high for exactly one edge fewer than the selected length and see no fault, then show the next edge confirming one. It must also show that a single low sample, or a low PWM phase, restarts the count. The stimulus drives inputs at the falling clock edge and counts rising edges exactly. It covers both window lengths and inserts a one-cycle gap to expose any count that is not reset. A clear attempt made while the flag is still high checks that the sticky latch holds.

// File: rtl/desat_pkg.sv
package desat_pkg;
  typedef enum logic [1:0] {
    OFF_HARD = 2'b00,
    OFF_SOFT = 2'b01,
    OFF_TWO  = 2'b10
  } off_style_e;

  function automatic off_style_e decode_mode(input logic [1:0] mode);
    case (mode)
      2'b01:   decode_mode = OFF_SOFT;
      2'b10:   decode_mode = OFF_TWO;
      default: decode_mode = OFF_HARD;
    endcase
  endfunction
endpackage

// File: rtl/desat_deglitch.sv
module desat_deglitch #(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic flag,
  input  logic sel_long,
  output logic trip
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] SHORT_W = CW'(SHORT_LEN);
  localparam logic [CW-1:0] LONG_W  = CW'(LONG_LEN);

  logic [CW-1:0] cnt_q, cnt_nxt, len;
  logic          active, cnt_en;

  assign len    = sel_long ? LONG_W : SHORT_W;
  assign active = arm & flag;

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    if (!active) begin
      cnt_nxt = '0;
      cnt_en  = (cnt_q != '0);
    end else if (cnt_q < len) begin
      cnt_nxt = cnt_q + 1'b1;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign trip = active & (cnt_q >= (len - 1'b1));
endmodule

// File: rtl/desat_fault_latch.sv
module desat_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic clr_stb,
  input  logic flag,
  output logic fault,
  output logic set_pulse
);
  logic fault_q, fault_nxt, clr_ok;

  assign clr_ok    = clr_stb & ~flag;
  assign set_pulse = trip & ~fault_q;

  always_comb begin
    fault_nxt = fault_q;
    if (trip)        fault_nxt = 1'b1;
    else if (clr_ok) fault_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_nxt;
  end

  assign fault = fault_q;
endmodule

// File: rtl/desat_offseq.sv
module desat_offseq
  import desat_pkg::*;
#(
  parameter int MID_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_pulse,
  input  logic       fault,
  input  logic [1:0] mode_in,
  output logic [1:0] style,
  output logic       mid
);
  localparam int MW = $clog2(MID_CYCLES + 1);
  localparam logic [MW-1:0] MID_W = MW'(MID_CYCLES);

  off_style_e    style_q, style_nxt;
  logic [MW-1:0] mid_q, mid_nxt;
  logic          mid_en;

  always_comb begin
    style_nxt = style_q;
    mid_nxt   = mid_q;
    mid_en    = 1'b0;
    if (set_pulse) begin
      style_nxt = decode_mode(mode_in);
      mid_nxt   = (decode_mode(mode_in) == OFF_TWO) ? MID_W : '0;
      mid_en    = 1'b1;
    end else if (!fault) begin
      style_nxt = OFF_HARD;
      mid_nxt   = '0;
      mid_en    = (mid_q != '0);
    end else if (mid_q != '0) begin
      mid_nxt = mid_q - 1'b1;
      mid_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) style_q <= OFF_HARD;
    else        style_q <= style_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mid_q <= '0;
    else if (mid_en) mid_q <= mid_nxt;
  end

  assign style = fault ? style_q : OFF_HARD;
  assign mid   = fault & (style_q == OFF_TWO) & (mid_q != '0);
endmodule

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int SHORT_LEN  = 4,
  parameter int LONG_LEN   = 16,
  parameter int MID_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       cmp_trip,
  input  logic       cfg_prot_en,
  input  logic       cfg_glitch_long,
  input  logic       cfg_safe_high,
  input  logic [1:0] cfg_off_mode,
  input  logic       cfg_dchg_en,
  input  logic       mask_flt,
  input  logic       clr_stb,
  output logic       gate_out,
  output logic [1:0] off_style,
  output logic       mid_level,
  output logic       chg_en,
  output logic       dchg_en,
  output logic       stat_desat,
  output logic       flt_n
);
  logic pwm_q, dchg_q, dchg_nxt;
  logic trip, fault, set_pulse;

  desat_deglitch #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) i_dg (
    .clk(clk), .rst_n(rst_n), .arm(cfg_prot_en & pwm_in), .flag(cmp_trip),
    .sel_long(cfg_glitch_long), .trip(trip)
  );

  desat_fault_latch i_lat (
    .clk(clk), .rst_n(rst_n), .trip(trip), .clr_stb(clr_stb),
    .flag(cmp_trip), .fault(fault), .set_pulse(set_pulse)
  );

  desat_offseq #(.MID_CYCLES(MID_CYCLES)) i_seq (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .fault(fault),
    .mode_in(cfg_off_mode), .style(off_style), .mid(mid_level)
  );

  assign dchg_nxt = cfg_dchg_en & pwm_q & ~pwm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      dchg_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_in;
      dchg_q <= dchg_nxt;
    end
  end

  assign gate_out   = fault ? cfg_safe_high : pwm_in;
  assign chg_en     = pwm_in & ~fault;
  assign dchg_en    = dchg_q;
  assign stat_desat = fault;
  assign flt_n      = ~(fault & ~mask_flt);
endmodule

// File: rtl/desat_guard_chk.sv
module desat_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_in,
  input logic       cmp_trip,
  input logic       cfg_prot_en,
  input logic       cfg_safe_high,
  input logic       cfg_dchg_en,
  input logic       mask_flt,
  input logic       clr_stb,
  input logic       gate_out,
  input logic [1:0] off_style,
  input logic       mid_level,
  input logic       chg_en,
  input logic       dchg_en,
  input logic       stat_desat,
  input logic       flt_n
);
  // R1
  fault_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_desat) |-> $past(cfg_prot_en & pwm_in & cmp_trip));
  // R2
  chg_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> (pwm_in && !stat_desat));
  // R3
  dchg_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_en |-> (!$past(pwm_in) && $past(cfg_dchg_en)));
  // R5
  safe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_desat |-> (gate_out == cfg_safe_high));
  // R7
  clear_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_desat) |-> $past(clr_stb && !cmp_trip));
  // R8
  fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_n == !(stat_desat && !mask_flt));
  // R9
  mid_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_level |-> (off_style == 2'b10 && stat_desat));
endmodule

bind desat_guard desat_guard_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cmp_trip(cmp_trip),
  .cfg_prot_en(cfg_prot_en), .cfg_safe_high(cfg_safe_high),
  .cfg_dchg_en(cfg_dchg_en), .mask_flt(mask_flt), .clr_stb(clr_stb),
  .gate_out(gate_out), .off_style(off_style), .mid_level(mid_level),
  .chg_en(chg_en), .dchg_en(dchg_en), .stat_desat(stat_desat), .flt_n(flt_n)
);

// File: tb/test_desat_guard.sv
module test_desat_guard;
  logic clk = 1'b0;
  logic rst_n;
  logic pwm_in, cmp_trip, cfg_prot_en, cfg_glitch_long, cfg_safe_high;
  logic [1:0] cfg_off_mode;
  logic cfg_dchg_en, mask_flt, clr_stb;
  logic gate_out, mid_level, chg_en, dchg_en, stat_desat, flt_n;
  logic [1:0] off_style;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  desat_guard i_desat_guard (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cmp_trip(cmp_trip),
    .cfg_prot_en(cfg_prot_en), .cfg_glitch_long(cfg_glitch_long),
    .cfg_safe_high(cfg_safe_high), .cfg_off_mode(cfg_off_mode),
    .cfg_dchg_en(cfg_dchg_en), .mask_flt(mask_flt), .clr_stb(clr_stb),
    .gate_out(gate_out), .off_style(off_style), .mid_level(mid_level),
    .chg_en(chg_en), .dchg_en(dchg_en), .stat_desat(stat_desat), .flt_n(flt_n)
  );

  // {glitch_long, safe_high, mode[1:0], mask, exp_style[1:0], exp_flt_n}
  localparam logic [7:0] VEC [6] = '{
    8'b0_0_00_0_00_0,
    8'b0_1_01_0_01_0,
    8'b1_0_10_1_10_1,
    8'b1_1_11_0_00_0,
    8'b0_1_10_1_10_1,
    8'b1_0_01_0_01_0
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_fault();
    cmp_trip = 1'b0; clr_stb = 1'b1;
    step(1);
    clr_stb = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_in = 1'b0; cmp_trip = 1'b0; cfg_prot_en = 1'b1;
    cfg_glitch_long = 1'b0; cfg_safe_high = 1'b0; cfg_off_mode = 2'b00;
    cfg_dchg_en = 1'b1; mask_flt = 1'b0; clr_stb = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    check("R11 stat", {1'b0, stat_desat}, 2'b00);
    check("R11 flt_n", {1'b0, flt_n}, 2'b01);
    check("R11 style", off_style, 2'b00);
    check("R11 mid", {mid_level, dchg_en}, 2'b00);
    check("R11 gate", {1'b0, gate_out}, 2'b00);

    // table walk: R4 short/long window, R5/R6/R8 per vector
    foreach (VEC[i]) begin
      automatic int len = VEC[i][7] ? 16 : 4;
      cfg_glitch_long = VEC[i][7]; cfg_safe_high = VEC[i][6];
      cfg_off_mode = VEC[i][5:4]; mask_flt = VEC[i][3];
      pwm_in = 1'b1; cmp_trip = 1'b1;
      step(len - 1);
      check("R4 not yet", {1'b0, stat_desat}, 2'b00);
      check("R6 idle style", off_style, 2'b00);
      step(1);
      check("R4 confirmed", {1'b0, stat_desat}, 2'b01);
      check("R5 gate", {1'b0, gate_out}, {1'b0, VEC[i][6]});
      check("R6 style", off_style, VEC[i][2:1]);
      check("R8 flt_n", {1'b0, flt_n}, {1'b0, VEC[i][0]});
      pwm_in = 1'b0;
      clear_fault();
      check("R7 cleared", {1'b0, stat_desat}, 2'b00);
    end
    mask_flt = 1'b0; cfg_glitch_long = 1'b0; cfg_off_mode = 2'b00; cfg_safe_high = 1'b0;

    // R1 disabled
    cfg_prot_en = 1'b0; pwm_in = 1'b1; cmp_trip = 1'b1;
    step(20);
    check("R1 no fault", {stat_desat, flt_n}, 2'b01);
    cfg_prot_en = 1'b1; cmp_trip = 1'b0; step(1);

    // R10 pwm low ignores flag, count restarts
    pwm_in = 1'b0; cmp_trip = 1'b1;
    step(20);
    check("R10 no fault", {1'b0, stat_desat}, 2'b00);
    pwm_in = 1'b1; step(3);
    pwm_in = 1'b0; step(1);
    pwm_in = 1'b1; step(3);
    check("R10 restart", {1'b0, stat_desat}, 2'b00);
    step(1);
    check("R10 fault after full run", {1'b0, stat_desat}, 2'b01);
    pwm_in = 1'b0; clear_fault();

    // R4 low sample restarts count
    pwm_in = 1'b1; cmp_trip = 1'b1; step(3);
    cmp_trip = 1'b0; step(1);
    cmp_trip = 1'b1; step(3);
    check("R4 gap restart", {1'b0, stat_desat}, 2'b00);
    step(1);
    check("R4 gap then run", {1'b0, stat_desat}, 2'b01);

    // R7 clear ignored while flag high; R5 hold while pwm toggles
    clr_stb = 1'b1; step(1); clr_stb = 1'b0;
    check("R7 held", {1'b0, stat_desat}, 2'b01);
    cmp_trip = 1'b0; pwm_in = 1'b0; step(2);
    check("R5 gate low held", {gate_out, stat_desat}, 2'b01);
    pwm_in = 1'b1; step(2);
    check("R5 gate held vs pwm", {gate_out, stat_desat}, 2'b01);
    check("R2 chg off in fault", {1'b0, chg_en}, 2'b00);
    step(5);
    check("R7 sticky", {1'b0, stat_desat}, 2'b01);
    clear_fault();
    check("R7 clear", {1'b0, stat_desat}, 2'b00);
    check("R2 chg on", {1'b0, chg_en}, 2'b01);
    pwm_in = 1'b0; step(1);
    check("R2 chg off pwm low", {1'b0, chg_en}, 2'b00);

    // R3 discharge pulse
    pwm_in = 1'b1; step(2);
    pwm_in = 1'b0; step(1);
    check("R3 pulse", {1'b0, dchg_en}, 2'b01);
    step(1);
    check("R3 one cycle", {1'b0, dchg_en}, 2'b00);
    cfg_dchg_en = 1'b0; pwm_in = 1'b1; step(2);
    pwm_in = 1'b0; step(1);
    check("R3 disabled", {1'b0, dchg_en}, 2'b00);
    check("R3 rising none", {1'b0, dchg_en}, 2'b00);

    // R9 two-level intermediate window
    cfg_off_mode = 2'b10; pwm_in = 1'b1; cmp_trip = 1'b1;
    step(4);
    check("R9 start", {mid_level, stat_desat}, 2'b11);
    cmp_trip = 1'b0;
    step(31);
    check("R9 last", {1'b0, mid_level}, 2'b01);
    step(1);
    check("R9 end", {mid_level, stat_desat}, 2'b01);
    check("R9 style kept", off_style, 2'b10);
    clear_fault();
    check("R6 style after clear", off_style, 2'b00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule